// File: doc/BRIEF.md
# SPI Ferroelectric Memory Burst Controller

This block is an SPI master that moves bursts of bytes to and from a serial ferroelectric memory with a 16-bit byte address. A host loads a start address, a byte count and a direction, then pulses a start strobe. The engine builds every frame on its own: opcode, two address bytes, then the data phase. Write data arrives on a valid/ready byte stream. Read data leaves on a second valid/ready byte stream.

A write first sends a one-byte write-enable frame. Chip select is then released for at least one serial clock period before the write frame opens. A burst keeps running at rising addresses inside one frame, and the address goes out only once. On a read, the engine shifts out one dummy zero byte for each byte it wants. The byte that comes back during each dummy is the data. Bytes received while the opcode or address is going out are dropped. The serial clock is a divided system clock in mode 0, and it is held low whenever chip select is high or whenever a data stream stalls.

Top module: `fram_burst_ctrl`

## Requirements
- R1: After reset, chip select is high, SCK and MOSI are low, and busy, done, write-ready and read-valid are all low.
- R2: Bytes are shifted MSB first in SPI mode 0. SCK stays high for exactly CLK_DIV system clocks at each pulse. MOSI changes only while SCK is low, and SCK is low whenever chip select is high.
- R3: A write opens with a frame carrying only the byte 0x06. Chip select then stays high for at least 2*CLK_DIV clocks. Next comes a frame starting with 0x02, then address bits 15:8, then address bits 7:0.
- R4: A read frame is 0x03, then address bits 15:8, then address bits 7:0, then one 0x00 byte per requested byte. The write-ready output is never high during a read.
- R5: A burst of N bytes travels in one frame of exactly 3+N bytes. The address is sent once, and data bytes follow in stream order.
- R6: With a count of zero, the frame ends right after the address low byte, and no stream handshake takes place. A write still sends its 0x06 frame first.
- R7: When the write stream stalls in the data phase, chip select stays low, SCK stays low, and write-ready stays high until the next byte is accepted.
- R8: Each byte received during a dummy byte comes out on the read port, in order, with rdata held stable while read-valid is high and read-ready is low. No further dummy byte starts while a read byte is still waiting. MISO bits received during the opcode and address bytes never produce read-valid.
- R9: Busy is high from the cycle after a start is accepted until the transaction ends. done pulses for one cycle per transaction, once chip select has been high for at least 2*CLK_DIV clocks.
- R10: A start strobe while busy is ignored. It produces no extra frame and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| dir_wr_i | input | 1 | 1 = write transaction, 0 = read |
| addr_i | input | 16 | First memory address |
| count_i | input | CNT_W | Number of data bytes (zero allowed) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| wdata_i | input | 8 | Write stream byte |
| wvalid_i | input | 1 | Write stream byte valid |
| wready_o | output | 1 | Engine ready for a write byte |
| rdata_o | output | 8 | Read stream byte |
| rvalid_o | output | 1 | Read stream byte valid |
| rready_i | input | 1 | Read stream consumer ready |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to memory |
| cs_n_o | output | 1 | Active-low chip select |
| miso_i | input | 1 | Serial data from memory |

## Verification
The bench sweeps byte counts from zero to five in both directions across several addresses, including the top of the address space. A memory model on the serial pins logs every frame and answers reads with a pattern computed from the address. Each case has a specific failure to catch:
- A count of zero catches an engine that sends a spurious data byte or waits forever for the stream.
- A long write-stream stall catches SCK running on or chip select dropping in the middle of a burst.
- A held read-ready catches a lost or overwritten read byte, and the model's 0xFF during the header catches header bits leaking out as data.
- A start strobed in the middle of a write would show up as a second frame set or an extra done pulse.
- The gap and pulse-width monitors catch a write frame that follows the enable frame too closely, and an uneven serial clock.

// File: rtl/fram_pkg.sv
package fram_pkg;

  localparam int ADDR_W = 16;

  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WEN,
    ST_MID,
    ST_HDR,
    ST_DATA,
    ST_TAIL
  } fram_state_t;

  // First byte put on the wire when a transaction is accepted
  function automatic logic [7:0] lead_byte(input logic is_wr);
    lead_byte = is_wr ? OPC_WEN : OPC_READ;
  endfunction

  // Header byte by index: 0 opcode, 1 address high, 2 address low
  function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic is_wr,
                                          input logic [ADDR_W-1:0] addr);
    case (idx)
      2'd0:    hdr_byte = is_wr ? OPC_WRITE : OPC_READ;
      2'd1:    hdr_byte = addr[15:8];
      default: hdr_byte = addr[7:0];
    endcase
  endfunction

  function automatic logic hdr_is_last(input logic [1:0] idx);
    hdr_is_last = (idx == 2'd2);
  endfunction

endpackage

// File: rtl/fram_tick_div.sv
module fram_tick_div #(
  parameter int CLK_DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (CLK_DIV <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = (cnt_q == CW'(CLK_DIV - 1));
      assign tick_o = run_i && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/fram_byte_shift.sv
module fram_byte_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       active_o,
  output logic       done_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o
);

  logic [7:0] tx_sr, rx_sr;
  logic [2:0] bit_q;
  logic       sck_q, act_q;

  assign done_o   = act_q && tick_i && sck_q && (bit_q == 3'd7);
  assign active_o = act_q;
  assign sck_o    = sck_q;
  assign mosi_o   = act_q ? tx_sr[7] : 1'b0;
  assign rx_o     = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
      act_q <= 1'b0;
    end else if (go_i) begin
      act_q <= 1'b1;
      tx_sr <= tx_i;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (act_q && tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_sr <= {rx_sr[6:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        tx_sr <= {tx_sr[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) act_q <= 1'b0;
      end
    end
  end

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R2
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (!active_o || done_o)); // R5

endmodule

// File: rtl/fram_burst_ctrl.sv
module fram_burst_ctrl
  import fram_pkg::*;
#(
  parameter int CLK_DIV = 5,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [15:0]      addr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic [7:0]       wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_n_o,
  input  logic             miso_i
);

  localparam int GAP_LEN = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_LEN + 1);

  fram_state_t         state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    rem_q;
  logic                wr_q;
  logic [1:0]          hdr_idx_q;
  logic [GAP_W-1:0]    gap_q;
  logic                done_q, rvalid_q;
  logic [7:0]          rdata_q;

  logic                sh_go, sh_active, sh_done, tick;
  logic [7:0]          sh_tx, sh_rx;

  // named internal events
  logic evt_accept, evt_gap_end, evt_hdr_last, evt_wr_take, evt_rd_launch, evt_data_done;

  assign evt_accept    = (state_q == ST_IDLE) && start_i;
  assign evt_gap_end   = ((state_q == ST_MID) || (state_q == ST_TAIL)) &&
                         (gap_q == GAP_W'(GAP_LEN - 1));
  assign evt_hdr_last  = (state_q == ST_HDR) && sh_done && hdr_is_last(hdr_idx_q);
  assign wready_o      = (state_q == ST_DATA) && wr_q && !sh_active && (rem_q != '0);
  assign evt_wr_take   = wready_o && wvalid_i;
  assign evt_rd_launch = (state_q == ST_DATA) && !wr_q && !sh_active && !rvalid_q &&
                         (rem_q != '0);
  assign evt_data_done = (state_q == ST_DATA) && sh_done;

  always_comb begin
    sh_go = 1'b0;
    sh_tx = 8'h00;
    case (state_q)
      ST_IDLE: begin
        sh_go = start_i;
        sh_tx = lead_byte(dir_wr_i);
      end
      ST_MID: begin
        sh_go = evt_gap_end;
        sh_tx = hdr_byte(2'd0, 1'b1, addr_q);
      end
      ST_HDR: begin
        sh_go = sh_done && !hdr_is_last(hdr_idx_q);
        sh_tx = hdr_byte(hdr_idx_q + 2'd1, wr_q, addr_q);
      end
      ST_DATA: begin
        sh_go = evt_wr_take || evt_rd_launch;
        sh_tx = wr_q ? wdata_i : 8'h00;
      end
      default: ;
    endcase
  end

  fram_tick_div #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (sh_active),
    .tick_o (tick)
  );

  fram_byte_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (sh_go),
    .tx_i     (sh_tx),
    .tick_i   (tick),
    .miso_i   (miso_i),
    .active_o (sh_active),
    .done_o   (sh_done),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .rx_o     (sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      wr_q      <= 1'b0;
      hdr_idx_q <= '0;
      gap_q     <= '0;
      done_q    <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (rvalid_q && rready_i) rvalid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (evt_accept) begin
          addr_q    <= addr_i;
          rem_q     <= count_i;
          wr_q      <= dir_wr_i;
          hdr_idx_q <= '0;
          state_q   <= dir_wr_i ? ST_WEN : ST_HDR;
        end
        ST_WEN: if (sh_done) begin
          gap_q   <= '0;
          state_q <= ST_MID;
        end
        ST_MID: begin
          gap_q <= gap_q + 1'b1;
          if (evt_gap_end) begin
            hdr_idx_q <= '0;
            state_q   <= ST_HDR;
          end
        end
        ST_HDR: if (sh_done) begin
          if (evt_hdr_last) begin
            gap_q   <= '0;
            state_q <= (rem_q == '0) ? ST_TAIL : ST_DATA;
          end else begin
            hdr_idx_q <= hdr_idx_q + 2'd1;
          end
        end
        ST_DATA: if (evt_data_done) begin
          rem_q <= rem_q - 1'b1;
          if (!wr_q) begin
            rvalid_q <= 1'b1;
            rdata_q  <= sh_rx;
          end
          if (rem_q == CNT_W'(1)) begin
            gap_q   <= '0;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          gap_q <= gap_q + 1'b1;
          if (evt_gap_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign cs_n_o   = (state_q == ST_IDLE) || (state_q == ST_MID) || (state_q == ST_TAIL);

  // checker state: cycles chip select has been high, saturating
  logic [GAP_W-1:0] cs_hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cs_hi_q <= GAP_W'(GAP_LEN);
    else if (!cs_n_o)                            cs_hi_q <= '0;
    else if (cs_hi_q != GAP_W'(GAP_LEN))         cs_hi_q <= cs_hi_q + 1'b1;
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o); // R2
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (cs_hi_q >= GAP_W'(GAP_LEN))); // R3
  AST_WREADY_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wready_o |-> wr_q); // R4
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && !sh_active) |-> (!sck_o && !cs_n_o)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o))); // R8
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !busy_o && (cs_hi_q >= GAP_W'(GAP_LEN)))); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(wr_q))); // R10

endmodule

// File: tb/fram_burst_ctrl_tb.sv
module fram_burst_ctrl_tb_top;

  localparam int TB_DIV = 2;
  localparam int GAPC   = 2 * TB_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, dir_wr_i = 1'b0;
  logic [15:0] addr_i = '0, count_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  wdata_i = '0;
  logic        wvalid_i = 1'b0, wready_o;
  logic [7:0]  rdata_o;
  logic        rvalid_o, rready_i = 1'b1;
  logic        sck_o, mosi_o, cs_n_o, miso_i;

  always #5 clk = ~clk;

  fram_burst_ctrl #(.CLK_DIV(TB_DIV), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
    .addr_i(addr_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
    .wdata_i(wdata_i), .wvalid_i(wvalid_i), .wready_o(wready_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .rready_i(rready_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .miso_i(miso_i)
  );

  int n_tests = 0, n_fail = 0;

  function automatic logic [7:0] rpat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] wpat(input logic [15:0] a, input int i);
    return 8'(a[7:0] + 8'(i * 37) + 8'd1);
  endfunction

  // memory model on the serial pins
  logic [7:0] log_b [16];
  int         fstart [4];
  int         log_n = 0, frame_n = 0, bit_i = 0, byte_i = 0;
  logic [7:0] cur = '0, opc = '0, ah = '0, al = '0;
  logic [7:0] mdrive;

  always @(negedge cs_n_o) begin
    if (frame_n < 4) fstart[frame_n] = log_n;
    frame_n++;
    bit_i = 0; byte_i = 0; opc = 8'h00;
  end

  always @(posedge sck_o) if (!cs_n_o) begin
    cur = {cur[6:0], mosi_o};
    bit_i++;
    if (bit_i == 8) begin
      bit_i = 0;
      if (log_n < 16) log_b[log_n] = cur;
      log_n++;
      if (byte_i == 0) opc = cur;
      if (byte_i == 1) ah = cur;
      if (byte_i == 2) al = cur;
      byte_i++;
    end
  end

  always @* begin
    if (opc == 8'h03 && byte_i >= 3) mdrive = rpat({ah, al} + 16'(byte_i - 3));
    else                             mdrive = 8'hFF;
  end
  assign miso_i = mdrive[3'(7 - bit_i)];

  // per-cycle monitor, sampled after the falling edge
  int sck_hi = 0, cs_hi = 1000, sck_err = 0, mosi_err = 0, sckcs_err = 0;
  int gap_err = 0, done_err = 0, hold_err = 0, done_cnt = 0, rx_n = 0;
  logic [7:0] rx_log [8];
  logic prev_sck = 0, prev_mosi = 0, prev_cs = 1, prev_rv = 0, prev_rr = 0;
  logic [7:0] prev_rd = '0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (sck_o) sck_hi++;
      else begin
        if (sck_hi != 0 && sck_hi != TB_DIV) sck_err++;
        sck_hi = 0;
      end
      if (sck_o && prev_sck && mosi_o != prev_mosi) mosi_err++;
      if (cs_n_o && sck_o) sckcs_err++;
      if (done_o) begin
        done_cnt++;
        if (!cs_n_o || cs_hi < GAPC) done_err++;
      end
      if (cs_n_o) cs_hi++;
      else begin
        if (prev_cs && cs_hi < GAPC) gap_err++;
        cs_hi = 0;
      end
      if (prev_rv && !prev_rr && (!rvalid_o || rdata_o != prev_rd)) hold_err++;
      if (rvalid_o && rready_i) begin
        if (rx_n < 8) rx_log[rx_n] = rdata_o;
        rx_n++;
      end
    end
    prev_sck = sck_o; prev_mosi = mosi_o; prev_cs = cs_n_o;
    prev_rv = rvalid_o; prev_rr = rready_i; prev_rd = rdata_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flen(input int k);
    if (k + 1 < frame_n) return fstart[k+1] - fstart[k];
    return log_n - fstart[k];
  endfunction

  task automatic clear_log();
    log_n = 0; frame_n = 0; rx_n = 0;
  endtask

  task automatic pulse_start(input logic wr, input logic [15:0] a, input int n);
    @(negedge clk);
    start_i = 1'b1; dir_wr_i = wr; addr_i = a; count_i = 16'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int gap,
                          input bit stall_chk, input bit poke);
    int d0, bad;
    clear_log();
    d0 = done_cnt;
    pulse_start(1'b1, a, n);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          if (gap > 0) repeat (gap) @(negedge clk);
          if (stall_chk && i > 0)
            check(!cs_n_o && !sck_o && wready_o, "R7 stall keeps CS low, SCK low, ready high",
                  {cs_n_o, sck_o, wready_o}, 3'b001);
          wvalid_i = 1'b1; wdata_i = wpat(a, i);
          while (!wready_o) @(negedge clk);
          @(negedge clk);
          wvalid_i = 1'b0;
        end
      end
      begin
        if (poke) begin
          repeat (60) @(negedge clk);
          check(busy_o, "R9 busy during transaction", busy_o, 1);
          start_i = 1'b1; dir_wr_i = 1'b0; addr_i = ~a; count_i = 16'd3;
          @(negedge clk);
          start_i = 1'b0;
        end
      end
      wait_done();
    join
    check(frame_n == 2, "R3 two frames per write", frame_n, 2);
    check(flen(0) == 1 && log_b[fstart[0]] == 8'h06, "R3 enable frame", log_b[fstart[0]], 8'h06);
    check(flen(1) == 3 + n, n == 0 ? "R6 zero-count frame length" : "R5 burst frame length",
          flen(1), 3 + n);
    bad = 0;
    if (log_b[fstart[1]] != 8'h02 || log_b[fstart[1]+1] != a[15:8] || log_b[fstart[1]+2] != a[7:0])
      bad++;
    for (int i = 0; i < n; i++) if (log_b[fstart[1]+3+i] != wpat(a, i)) bad++;
    check(bad == 0, "R3 R5 write header and data bytes", bad, 0);
    check(done_cnt == d0 + 1, poke ? "R10 one done despite extra start" : "R9 one done pulse",
          done_cnt - d0, 1);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input bit backpress);
    int d0, bad, zbad, hbad;
    logic [7:0] held;
    clear_log();
    d0 = done_cnt;
    if (backpress) rready_i = 1'b0;
    pulse_start(1'b0, a, n);
    if (backpress) begin
      while (!rvalid_o) @(negedge clk);
      held = rdata_o;
      hbad = 0;
      repeat (30) begin
        @(negedge clk);
        if (!rvalid_o || rdata_o != held || sck_o) hbad++;
      end
      check(hbad == 0, "R8 rdata held and no new dummy while not ready", hbad, 0);
      rready_i = 1'b1;
    end
    wait_done();
    check(frame_n == 1 && flen(0) == 3 + n, n == 0 ? "R6 zero-count read length" : "R5 read frame length",
          flen(0), 3 + n);
    bad = 0; zbad = 0;
    if (log_b[0] != 8'h03 || log_b[1] != a[15:8] || log_b[2] != a[7:0]) bad++;
    for (int i = 0; i < n; i++) if (log_b[3+i] != 8'h00) zbad++;
    check(bad == 0 && zbad == 0, "R4 read header and dummy bytes", bad + zbad, 0);
    check(rx_n == n, "R8 one read byte per dummy", rx_n, n);
    bad = 0;
    for (int i = 0; i < n && i < 8; i++) if (rx_log[i] != rpat(a + 16'(i))) bad++;
    check(bad == 0, "R4 read data matches memory", bad, 0);
    check(done_cnt == d0 + 1, "R9 one done per read", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] addrs [3];
    addrs[0] = 16'h0000; addrs[1] = 16'hA5C3; addrs[2] = 16'hFFFE;
    repeat (3) @(negedge clk);
    check(cs_n_o && !sck_o && !mosi_o && !busy_o && !done_o && !wready_o && !rvalid_o,
          "R1 reset state", {cs_n_o, sck_o, mosi_o, busy_o, done_o, wready_o, rvalid_o}, 7'b1000000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n_o && !busy_o, "R1 idle after reset", {cs_n_o, busy_o}, 2'b10);

    for (int k = 0; k < 3; k++)
      for (int n = 0; n <= 5; n++) begin
        do_write(addrs[k], n, 0, 1'b0, 1'b0);
        do_read(addrs[k], n, 1'b0);
      end

    do_write(16'h1234, 3, 70, 1'b1, 1'b0);
    do_read(16'h4321, 3, 1'b1);
    do_write(16'h0F0F, 2, 0, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    check(frame_n == 2 && !busy_o, "R10 no frame from ignored start", frame_n, 2);

    check(sck_err == 0, "R2 SCK high width", sck_err, 0);
    check(mosi_err == 0, "R2 MOSI stable while SCK high", mosi_err, 0);
    check(sckcs_err == 0, "R2 SCK low with CS high", sckcs_err, 0);
    check(gap_err == 0, "R3 CS high gap", gap_err, 0);
    check(done_err == 0, "R9 done after CS gap", done_err, 0);
    check(hold_err == 0, "R8 read stream hold", hold_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule